// File: doc/BRIEF.md
# Sampled-Pulse Peak Trigger Channel Bank

This block takes a free-running stream of shaped-pulse samples (one sample per clock, 100 MS/s in the target system) for a bank of independent trigger cells and turns each pulse into one trigger record. A record carries a gain-corrected pulse height, a discriminator bit and a coarse timestamp. Each channel finds a local maximum in its sample stream. It then reports either that maximum or the sum of the samples along the rising edge that led to it. The value is scaled by a per-channel gain factor and compared against a programmable threshold. The record is delayed by a programmable number of clocks so that records from many boards line up before serialization.

Configuration is write-only through a small address/data port. The threshold, output delay, mode and dead time are shared by all channels. Each channel has its own gain entry. Samples are unsigned. The reset input is asynchronous and active low, and its release is synchronized inside the block with two flops.

Top module: `pk_trig_top`

## Requirements
- R1: While reset is active and right after reset, every hit strobe, height, discriminator bit and timestamp output is zero.
- R2: A channel declares a peak at sample p only when p is strictly greater than the threshold, strictly greater than the sample before it, strictly greater than the sample after it, and the channel is not in dead time. A sample equal to the threshold, or the first sample of a flat top, produces no record.
- R3: With mode code 0 (written at address 2), the reported raw height is the peak sample value.
- R4: With mode code 1, the raw height is the sum of the peak sample and the samples before it back to the start of its strictly increasing run. The run starts at the last sample that was not greater than its predecessor, and that sample is included. The sum saturates at 2^(SW+4)-1.
- R5: The corrected height is floor(raw × g / 64), saturated at 2^(SW+4)-1. Here g is the 8-bit gain of the channel at address 32 + channel index. Each gain resets to 64.
- R6: The discriminator bit is 1 exactly when the corrected height is strictly greater than the threshold at address 0.
- R7: The timestamp is the sample index of the peak modulo 2^16. Index 0 is the sample captured on the third rising clock edge after reset is released.
- R8: The record appears on the outputs after the rising edge that lies 3 + D edges after the edge that captured the peak sample. D (0 to 31) is written at address 1.
- R9: Each declared peak produces exactly one single-cycle hit strobe on its channel, and there are no other strobes.
- R10: With dead time T (address 3), a peak whose index is no more than T above the previous accepted peak of the same channel is dropped.
- R11: Channels are independent: stimulus and gain on one channel do not alter the records of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | NCH*SW | Packed samples, channel c at bits [c*SW +: SW] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| hit_o | output | NCH | One-cycle record strobe per channel |
| height_o | output | NCH*(SW+4) | Corrected heights, channel c at bits [c*(SW+4) +: SW+4] |
| disc_o | output | NCH | Discriminator bit per channel |
| stamp_o | output | NCH*16 | Peak sample index per channel |

## Verification
A peak sample captured on edge E is confirmed one edge later, when the next sample arrives. The detector register fires on edge E+2 and the gain stage on edge E+3, so the record is due after edge E+3+D. The bench keeps a reference model that is advanced at each falling edge when a sample is driven. When the model confirms a peak, it files the expected record in a slot keyed by the absolute edge number 3+D edges ahead. At every later falling edge, each slot is compared with the outputs, so a strobe that comes early, late or twice is reported in the cycle where it differs. Configuration is changed only on an idle stream, so every record in flight belongs to a single setting.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int CFG_AW = 6;
  localparam int CFG_DW = 16;

  localparam logic [CFG_AW-1:0] ADR_THR       = 6'd0;
  localparam logic [CFG_AW-1:0] ADR_DELAY     = 6'd1;
  localparam logic [CFG_AW-1:0] ADR_MODE      = 6'd2;
  localparam logic [CFG_AW-1:0] ADR_DEAD      = 6'd3;
  localparam int                ADR_GAIN_BASE = 32;

  typedef enum logic {
    MODE_PEAK = 1'b0,
    MODE_RSUM = 1'b1
  } pk_mode_e;
endpackage

// File: rtl/pk_cfg_regs.sv
module pk_cfg_regs
  import pk_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int HW   = 16,
  parameter int GW   = 8,
  parameter int GF   = 6,
  parameter int DLYW = 5,
  parameter int DTW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [CFG_AW-1:0]        addr_i,
  input  logic [CFG_DW-1:0]        wdata_i,
  output logic [HW-1:0]            thr_o,
  output logic [DLYW-1:0]          dly_o,
  output pk_mode_e                 mode_o,
  output logic [DTW-1:0]           dead_o,
  output logic [NCH-1:0][GW-1:0]   gain_o
);
  localparam logic [GW-1:0] GAIN_UNITY = GW'(1 << GF);

  logic [HW-1:0]   thr_q, thr_d;
  logic [DLYW-1:0] dly_q, dly_d;
  pk_mode_e        mode_q, mode_d;
  logic [DTW-1:0]  dead_q, dead_d;

  always_comb begin
    thr_d  = thr_q;
    dly_d  = dly_q;
    mode_d = mode_q;
    dead_d = dead_q;
    if (we_i) begin
      unique case (addr_i)
        ADR_THR:   thr_d  = wdata_i[HW-1:0];
        ADR_DELAY: dly_d  = wdata_i[DLYW-1:0];
        ADR_MODE:  mode_d = pk_mode_e'(wdata_i[0]);
        ADR_DEAD:  dead_d = wdata_i[DTW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      dly_q  <= '0;
      mode_q <= MODE_PEAK;
      dead_q <= '0;
    end else if (we_i) begin
      thr_q  <= thr_d;
      dly_q  <= dly_d;
      mode_q <= mode_d;
      dead_q <= dead_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_gain
    logic          sel;
    logic [GW-1:0] g_q;
    assign sel = we_i && (addr_i == CFG_AW'(ADR_GAIN_BASE + c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   g_q <= GAIN_UNITY;
      else if (sel) g_q <= wdata_i[GW-1:0];
    end
    assign gain_o[c] = g_q;
  end

  assign thr_o  = thr_q;
  assign dly_o  = dly_q;
  assign mode_o = mode_q;
  assign dead_o = dead_q;
endmodule

// File: rtl/pk_peak.sv
module pk_peak
  import pk_pkg::*;
#(
  parameter int SW  = 12,
  parameter int HW  = 16,
  parameter int DTW = 8,
  parameter int TSW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   samp_i,
  input  logic [HW-1:0]   thr_i,
  input  pk_mode_e        mode_i,
  input  logic [DTW-1:0]  dead_i,
  input  logic [TSW-1:0]  now_i,
  output logic            v_o,
  output logic [HW-1:0]   raw_o,
  output logic [TSW-1:0]  ts_o
);
  localparam int PAD = HW - SW;
  localparam logic [TSW-1:0] TS_LAG = TSW'(2);

  logic [SW-1:0]  s0_q, s1_q, s2_q;
  logic [HW-1:0]  acc_q, acc_d;
  logic [HW:0]    acc_sum;
  logic [DTW-1:0] dead_q, dead_d;
  logic           fire;
  logic           v_q;
  logic [HW-1:0]  raw_q, raw_d;
  logic [TSW-1:0] ts_q, ts_d;

  // rising-run accumulator follows the sample that moves into s1 next
  always_comb begin
    acc_sum = {1'b0, acc_q} + {{(PAD + 1){1'b0}}, s0_q};
    if (s0_q > s1_q) acc_d = acc_sum[HW] ? '1 : acc_sum[HW-1:0];
    else             acc_d = {{PAD{1'b0}}, s0_q};
  end

  always_comb begin
    fire = ({{PAD{1'b0}}, s1_q} > thr_i) && (s1_q > s2_q) &&
           (s0_q < s1_q) && (dead_q == '0);
    if (fire)               dead_d = dead_i;
    else if (dead_q != '0)  dead_d = dead_q - 1'b1;
    else                    dead_d = dead_q;
    raw_d = (mode_i == MODE_RSUM) ? acc_q : {{PAD{1'b0}}, s1_q};
    ts_d  = now_i - TS_LAG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q   <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      acc_q  <= '0;
      dead_q <= '0;
      v_q    <= 1'b0;
    end else begin
      s0_q   <= samp_i;
      s1_q   <= s0_q;
      s2_q   <= s1_q;
      acc_q  <= acc_d;
      dead_q <= dead_d;
      v_q    <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      ts_q  <= '0;
    end else if (fire) begin
      raw_q <= raw_d;
      ts_q  <= ts_d;
    end
  end

  assign v_o   = v_q;
  assign raw_o = raw_q;
  assign ts_o  = ts_q;

  // R9: a confirmed peak needs a lower sample after it, so strobes never touch
  a_r9_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> !v_q);

  // R10: while the dead counter runs, no record may leave the detector
  a_r10_dead_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (dead_q != '0) |=> !v_q);
endmodule

// File: rtl/pk_gain.sv
module pk_gain #(
  parameter int HW  = 16,
  parameter int GW  = 8,
  parameter int GF  = 6,
  parameter int TSW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_i,
  input  logic [HW-1:0]   raw_i,
  input  logic [TSW-1:0]  ts_i,
  input  logic [GW-1:0]   gain_i,
  input  logic [HW-1:0]   thr_i,
  output logic            v_o,
  output logic [HW-1:0]   h_o,
  output logic            disc_o,
  output logic [TSW-1:0]  ts_o
);
  localparam int PW = HW + GW;
  localparam logic [GW-1:0] GAIN_UNITY = GW'(1 << GF);

  logic [PW-1:0]  prod, scl;
  logic [HW-1:0]  corr;
  logic           disc_d;
  logic           v_q, disc_q;
  logic [HW-1:0]  h_q;
  logic [TSW-1:0] ts_q;

  always_comb begin
    prod   = {{GW{1'b0}}, raw_i} * {{HW{1'b0}}, gain_i};
    scl    = prod >> GF;
    corr   = (|scl[PW-1:HW]) ? '1 : scl[HW-1:0];
    disc_d = corr > thr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      disc_q <= 1'b0;
      ts_q   <= '0;
    end else if (v_i) begin
      h_q    <= corr;
      disc_q <= disc_d;
      ts_q   <= ts_i;
    end
  end

  assign v_o    = v_q;
  assign h_o    = h_q;
  assign disc_o = disc_q;
  assign ts_o   = ts_q;

  // R5: a unity gain passes the raw height through unchanged
  a_r5_unity_gain : assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && gain_i == GAIN_UNITY) |=> (h_q == $past(raw_i)));
endmodule

// File: rtl/pk_dly.sv
module pk_dly #(
  parameter int W    = 33,
  parameter int DLYW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DLYW-1:0] dly_i,
  input  logic            v_i,
  input  logic [W-1:0]    d_i,
  output logic            v_o,
  output logic [W-1:0]    d_o
);
  localparam int DEPTH = (1 << DLYW) - 1;

  logic [DEPTH-1:0]        vs_q;
  logic [DEPTH-1:0][W-1:0] ds_q;
  logic [DLYW-1:0]         tap;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic          v_in;
    logic [W-1:0]  d_in;
    if (i == 0) begin : g_head
      assign v_in = v_i;
      assign d_in = d_i;
    end else begin : g_body
      assign v_in = vs_q[i-1];
      assign d_in = ds_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_q[i] <= 1'b0;
      else        vs_q[i] <= v_in;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ds_q[i] <= '0;
      else if (v_in) ds_q[i] <= d_in;
    end
  end

  always_comb begin
    tap = dly_i - 1'b1;
    if (dly_i == '0) begin
      v_o = v_i;
      d_o = d_i;
    end else begin
      v_o = vs_q[tap];
      d_o = ds_q[tap];
    end
  end

  // R8: a one-clock setting that has held for a cycle replays the last input strobe
  a_r8_one_stage : assert property (@(posedge clk) disable iff (!rst_n)
    (dly_i == DLYW'(1) && $past(dly_i) == DLYW'(1)) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/pk_trig_top.sv
module pk_trig_top
  import pk_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int SW   = 12,
  parameter int GW   = 8,
  parameter int GF   = 6,
  parameter int DLYW = 5,
  parameter int DTW  = 8,
  parameter int TSW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*SW-1:0]     samp_i,
  input  logic                  cfg_we_i,
  input  logic [5:0]            cfg_addr_i,
  input  logic [15:0]           cfg_wdata_i,
  output logic [NCH-1:0]        hit_o,
  output logic [NCH*(SW+4)-1:0] height_o,
  output logic [NCH-1:0]        disc_o,
  output logic [NCH*TSW-1:0]    stamp_o
);
  localparam int HW = SW + 4;
  localparam int RW = HW + 1 + TSW;

  logic                 rs1_q, rs2_q, rst_s;
  logic [TSW-1:0]       cnt_q, cnt_d;
  logic [HW-1:0]        thr;
  logic [DLYW-1:0]      dly;
  pk_mode_e             mode;
  logic [DTW-1:0]       dead;
  logic [NCH-1:0][GW-1:0] gain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s = rs2_q;

  assign cnt_d = cnt_q + 1'b1;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  pk_cfg_regs #(
    .NCH(NCH), .HW(HW), .GW(GW), .GF(GF), .DLYW(DLYW), .DTW(DTW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_s), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .thr_o(thr), .dly_o(dly), .mode_o(mode),
    .dead_o(dead), .gain_o(gain)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic           a_v, b_v, b_disc;
    logic [HW-1:0]  a_raw, b_h;
    logic [TSW-1:0] a_ts, b_ts;
    logic [RW-1:0]  rec_in, rec_out;
    logic           o_v;

    pk_peak #(.SW(SW), .HW(HW), .DTW(DTW), .TSW(TSW)) u_peak (
      .clk(clk), .rst_n(rst_s), .samp_i(samp_i[c*SW +: SW]), .thr_i(thr),
      .mode_i(mode), .dead_i(dead), .now_i(cnt_q),
      .v_o(a_v), .raw_o(a_raw), .ts_o(a_ts)
    );

    pk_gain #(.HW(HW), .GW(GW), .GF(GF), .TSW(TSW)) u_gain (
      .clk(clk), .rst_n(rst_s), .v_i(a_v), .raw_i(a_raw), .ts_i(a_ts),
      .gain_i(gain[c]), .thr_i(thr),
      .v_o(b_v), .h_o(b_h), .disc_o(b_disc), .ts_o(b_ts)
    );

    assign rec_in = {b_disc, b_h, b_ts};

    pk_dly #(.W(RW), .DLYW(DLYW)) u_dly (
      .clk(clk), .rst_n(rst_s), .dly_i(dly), .v_i(b_v), .d_i(rec_in),
      .v_o(o_v), .d_o(rec_out)
    );

    assign hit_o[c]               = o_v;
    assign disc_o[c]              = rec_out[RW-1];
    assign height_o[c*HW +: HW]   = rec_out[TSW +: HW];
    assign stamp_o[c*TSW +: TSW]  = rec_out[TSW-1:0];
  end

  // R7: the sample index advances by one on every clock out of reset
  a_r7_stamp_step : assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/sim_pk_trig_top.sv
module sim_pk_trig_top;
  localparam int NCH = 2;
  localparam int SW  = 8;
  localparam int HW  = SW + 4;
  localparam int TSW = 16;
  localparam int HMAX = (1 << HW) - 1;
  localparam int RING = 64;

  logic                  clk;
  logic                  rst_n;
  logic [NCH*SW-1:0]     samp_i;
  logic                  cfg_we_i;
  logic [5:0]            cfg_addr_i;
  logic [15:0]           cfg_wdata_i;
  logic [NCH-1:0]        hit_o;
  logic [NCH*HW-1:0]     height_o;
  logic [NCH-1:0]        disc_o;
  logic [NCH*TSW-1:0]    stamp_o;

  pk_trig_top #(.NCH(NCH), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .hit_o(hit_o),
    .height_o(height_o), .disc_o(disc_o), .stamp_o(stamp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  int ec = 0;
  string cur = "R1";
  int drv [NCH];
  int h1 [NCH], h2 [NCH], acc [NCH], dcnt [NCH], gain [NCH];
  int thr = 0, dly = 0, mode = 0, dt = 0;
  bit ev [NCH][RING];
  int eh [NCH][RING], ed [NCH][RING], ets [NCH][RING];
  int n_exp = 0, n_obs = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) ec <= ec + 1;

  task automatic fail(input string what, input int act, input int exp);
    nerr++;
    $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", cur, what, act, exp, ec);
  endtask

  task automatic step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      int s = ec % RING;
      int oh = int'(height_o[c*HW +: HW]);
      int ot = int'(stamp_o[c*TSW +: TSW]);
      if (hit_o[c]) n_obs++;
      if (ev[c][s] || hit_o[c]) begin
        nchk++;
        if (ev[c][s] != hit_o[c]) fail($sformatf("ch%0d strobe R9", c), int'(hit_o[c]), int'(ev[c][s]));
        else if (oh != eh[c][s]) fail($sformatf("ch%0d height", c), oh, eh[c][s]);
        else if (int'(disc_o[c]) != ed[c][s]) fail($sformatf("ch%0d disc R6", c), int'(disc_o[c]), ed[c][s]);
        else if (ot != ets[c][s]) fail($sformatf("ch%0d stamp R7", c), ot, ets[c][s]);
      end
      ev[c][s] = 1'b0;
    end
    for (int c = 0; c < NCH; c++) begin
      int x = drv[c];
      samp_i[c*SW +: SW] = SW'(x);
      if (h1[c] > thr && h1[c] > h2[c] && x < h1[c] && dcnt[c] == 0) begin
        int raw = (mode == 1) ? acc[c] : h1[c];
        int corr = (raw * gain[c]) / 64;
        int s = (ec + 3 + dly) % RING;
        if (corr > HMAX) corr = HMAX;
        ev[c][s] = 1'b1;
        eh[c][s] = corr;
        ed[c][s] = (corr > thr) ? 1 : 0;
        ets[c][s] = (ec - 3) & 16'hffff;
        n_exp++;
        dcnt[c] = dt;
      end else if (dcnt[c] > 0) dcnt[c]--;
      if (x > h1[c]) begin
        acc[c] = acc[c] + x;
        if (acc[c] > HMAX) acc[c] = HMAX;
      end else acc[c] = x;
      h2[c] = h1[c];
      h1[c] = x;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NCH; c++) drv[c] = 0;
      step();
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_addr_i = 6'(a);
    cfg_wdata_i = 16'(d);
    cfg_we_i = 1'b1;
    idle(1);
    cfg_we_i = 1'b0;
    if (a == 0) thr = d;
    else if (a == 1) dly = d;
    else if (a == 2) mode = d;
    else if (a == 3) dt = d;
    else gain[a-32] = d;
    idle(2);
  endtask

  function automatic int tri_at(input int t, input int r, input int s);
    if (t <= r) return t * s;
    if (t <= 2 * r) return (2 * r - t) * s;
    return 0;
  endfunction

  task automatic tri2(input int r0, input int s0, input int r1, input int s1);
    int len = 2 * ((r0 > r1) ? r0 : r1) + 2;
    for (int t = 0; t <= len; t++) begin
      drv[0] = tri_at(t, r0, s0);
      drv[1] = tri_at(t, r1, s1);
      step();
    end
    idle(40);
  endtask

  task automatic seq2(input int a [8], input int b [8]);
    for (int t = 0; t < 8; t++) begin
      drv[0] = a[t];
      drv[1] = b[t];
      step();
    end
    idle(40);
  endtask

  task automatic count_check();
    nchk++;
    if (n_obs != n_exp) fail("record count", n_obs, n_exp);
    n_obs = 0;
    n_exp = 0;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    samp_i = '0;
    cfg_we_i = 1'b0;
    cfg_addr_i = '0;
    cfg_wdata_i = '0;
    for (int c = 0; c < NCH; c++) begin
      drv[c] = 0; h1[c] = 0; h2[c] = 0; acc[c] = 0; dcnt[c] = 0; gain[c] = 64;
      for (int s = 0; s < RING; s++) ev[c][s] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    nchk++;
    if (hit_o != '0 || height_o != '0 || disc_o != '0 || stamp_o != '0)
      fail("R1 outputs in reset", int'(hit_o), 0);
    rst_n = 1'b1;
    idle(6);
    nchk++;
    if (hit_o != '0 || height_o != '0 || disc_o != '0 || stamp_o != '0)
      fail("R1 outputs after reset", int'(hit_o), 0);

    // R3, R8: peak heights across every delay setting, distinct per channel (R11)
    cur = "R8";
    wr(0, 20);
    for (int d = 0; d < 32; d++) begin
      wr(1, d);
      tri2(3 + d % 4, 7, 2 + d % 3, 11 + d);
    end
    count_check();

    // R2: threshold equality, single-sample spike, flat top, double hump
    cur = "R2";
    wr(1, 4);
    wr(0, 40);
    tri2(4, 10, 1, 41);
    count_check();
    seq2('{0, 30, 60, 60, 30, 0, 0, 0}, '{0, 50, 45, 60, 10, 0, 0, 0});
    count_check();

    // R4: rising partial sums, including a run that starts at a nonzero valley
    cur = "R4";
    wr(0, 20);
    wr(2, 1);
    for (int k = 1; k <= 8; k++) tri2(k + 1, 5 + k, k + 2, 3 * k);
    seq2('{0, 10, 30, 20, 25, 40, 5, 0}, '{0, 0, 22, 21, 23, 24, 0, 0});
    for (int t = 0; t <= 256; t++) begin
      drv[0] = (t < 256) ? t : 0;
      drv[1] = (t % 8) * 3;
      step();
    end
    idle(40);
    count_check();

    // R5, R6, R11: gain sweep with mirrored gains, disc edges, saturation
    cur = "R5";
    wr(2, 0);
    wr(0, 100);
    for (int g = 0; g < 256; g += 17) begin
      wr(32, g);
      wr(33, 255 - g);
      tri2(5, 40, 5, 51);
    end
    cur = "R6";
    wr(32, 32);
    wr(33, 33);
    tri2(5, 40, 5, 40);
    cur = "R5";
    wr(2, 1);
    wr(32, 255);
    wr(33, 64);
    tri2(9, 28, 9, 28);
    count_check();

    // R10: dead time against peak spacing, opposite spacing on each channel (R11)
    cur = "R10";
    wr(2, 0);
    wr(0, 10);
    wr(32, 64);
    wr(33, 64);
    for (int t = 0; t < 8; t++) begin
      wr(3, t);
      for (int z = 0; z <= 4; z++) begin
        for (int i = 0; i < 13; i++) begin
          int p0 = (i < 4) ? tri_at(i, 2, 20) : ((i >= 4 + z) ? tri_at(i - 4 - z, 2, 20) : 0);
          int p1 = (i < 4) ? tri_at(i, 2, 25) : ((i >= 8 - z) ? tri_at(i - 8 + z, 2, 25) : 0);
          drv[0] = p0;
          drv[1] = p1;
          step();
        end
        idle(40);
      end
    end
    count_check();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule